// File: doc/BRIEF.md
# Split Transfer Response Merger

This block sits between a load/store unit and a retirement monitor. For every memory instruction it takes one request descriptor and then the bus responses that belong to it. A misaligned access that crosses a word boundary arrives as two sub-transfers, so it has two responses. Once every awaited response has arrived, the block emits one valid-qualified summary. The summary carries the start address, the assembled read data, a merged error flag, a merged exclusive-okay flag and the memory type.

Whether a store half is bufferable changes what the summary reports. A bufferable store half is never waited on. It adds nothing to the error flag, and it forces the exclusive-okay flag low. A store whose halves are all bufferable is therefore reported as soon as it is accepted. Responses are delivered in issue order and only for awaited halves: every load half, and each non-bufferable store half.

Top module: `xfer_merge`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after an accepted request that awaits responses until the cycle after its final awaited response has been taken. Exactly one summary follows each request. `out_valid` is a one-cycle pulse in the cycle after the final awaited response.
- R3: For an unsplit load, `out_err` equals the error bit of its single response, and `out_exokay` equals its exokay bit.
- R4: For a split load, `out_err` is the OR of both response error bits, and `out_exokay` is the AND of both exokay bits.
- R5: A store half is awaited only when its bufferable bit is 0, and only awaited halves contribute to `out_err`. A store with no awaited half reports `out_err`=0, with `out_valid` in the cycle after acceptance. A mixed split store reports the error of its non-bufferable half alone.
- R6: A store with any bufferable half in use reports `out_exokay`=0. Otherwise a store's `out_exokay` is the AND of the exokay bits of its responses.
- R7: `out_addr` is the request address unchanged, including its low byte-offset bits. `out_mtype` is the request memory type, which describes the first sub-transfer.
- R8: The read data is little-endian. Result byte i is byte (off+i) of the first response word when off+i < 4, and byte (off+i-4) of the second response word otherwise, where off is `req_addr[1:0]`. Bytes at and above 2^`req_size` (0 = byte, 1 = half, 2 = word) read 0. A store reports `out_rdata`=0.
- R9: A response strobe that arrives while no request is collecting produces no summary and does not change a later summary.
- R10: For loads the bufferable bits are ignored: every load half is awaited and contributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request descriptor present |
| req_ready | output | 1 | Block can accept a descriptor |
| req_addr | input | ADDR_W | Start address of the first sub-transfer |
| req_size | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| req_store | input | 1 | 1 store, 0 load |
| req_split | input | 1 | Access is split into two sub-transfers |
| req_buf0 | input | 1 | First sub-transfer is bufferable |
| req_buf1 | input | 1 | Second sub-transfer is bufferable |
| req_mtype | input | MTYPE_W | Memory type of the first sub-transfer |
| rsp_valid | input | 1 | Response strobe for the next awaited half |
| rsp_rdata | input | DATA_W | Response read word |
| rsp_err | input | 1 | Response bus error |
| rsp_exokay | input | 1 | Response exclusive okay |
| out_valid | output | 1 | Summary valid, one-cycle pulse |
| out_addr | output | ADDR_W | Reported start address |
| out_rdata | output | DATA_W | Assembled read data |
| out_err | output | 1 | Merged error |
| out_exokay | output | 1 | Merged exclusive okay |
| out_mtype | output | MTYPE_W | Reported memory type |

## Verification
The bench aims at mixed split stores in both orientations. A design that ORs both halves regardless of attribute, or waits on the bufferable half, would report a stale error or hang with `req_ready` low. It checks stores with no awaited half, where a design that waits for a response never produces a summary. Split loads at every byte offset are checked, where a wrong shift or lane mask scrambles or leaks bytes into the high lanes. The bench also applies loads with bufferable bits set, where a design that skips a load half emits the summary one response early. Finally, it sends stray response strobes while idle, which a careless design would count toward the next request.

// File: rtl/xfer_merge_pkg.sv
package xfer_merge_pkg;

  typedef enum logic {
    PH_IDLE    = 1'b0,
    PH_COLLECT = 1'b1
  } phase_e;

  localparam int unsigned MAX_HALVES = 2;
  localparam int unsigned CNT_W      = $clog2(MAX_HALVES + 1);

  // a half is waited on unless it is a bufferable store half
  function automatic logic half_awaited(input logic is_store, input logic bufferable);
    return !is_store || !bufferable;
  endfunction

  function automatic logic [CNT_W-1:0] awaited_count(input logic is_store,
                                                     input logic split,
                                                     input logic buf0,
                                                     input logic buf1);
    logic [CNT_W-1:0] n;
    n = CNT_W'(half_awaited(is_store, buf0));
    if (split) n = n + CNT_W'(half_awaited(is_store, buf1));
    return n;
  endfunction

  // exclusive okay cannot be claimed once a bufferable store half is involved
  function automatic logic ok_allowed(input logic is_store,
                                      input logic split,
                                      input logic buf0,
                                      input logic buf1);
    return !(is_store && (buf0 || (split && buf1)));
  endfunction

endpackage

// File: rtl/xfer_merge_track.sv
module xfer_merge_track
  import xfer_merge_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] need_i,
  input  logic             rsp_valid_i,
  output logic             collect_o,
  output logic             take_o,
  output logic             first_o,
  output logic             last_o
);

  phase_e           phase_q;
  logic [CNT_W-1:0] remain_q;
  logic             got_one_q;

  assign collect_o = (phase_q == PH_COLLECT);
  assign take_o    = rsp_valid_i && collect_o;
  assign first_o   = take_o && !got_one_q;
  assign last_o    = take_o && (remain_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      remain_q  <= '0;
      got_one_q <= 1'b0;
    end else if (accept_i && (need_i != '0)) begin
      phase_q   <= PH_COLLECT;
      remain_q  <= need_i;
      got_one_q <= 1'b0;
    end else if (take_o) begin
      remain_q  <= remain_q - CNT_W'(1);
      got_one_q <= 1'b1;
      if (last_o) phase_q <= PH_IDLE;
    end
  end

  AST_ACCEPT_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && (need_i != '0)) |=> collect_o); // R2
  AST_COLLECT_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    collect_o |-> (remain_q != '0)); // R2

endmodule

// File: rtl/xfer_merge_status.sv
module xfer_merge_status (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic ok_seed_i,
  input  logic take_i,
  input  logic rsp_err_i,
  input  logic rsp_ok_i,
  output logic fin_err_o,
  output logic fin_ok_o
);

  logic err_acc_q;
  logic ok_acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_acc_q <= 1'b0;
      ok_acc_q  <= 1'b0;
    end else if (accept_i) begin
      err_acc_q <= 1'b0;
      ok_acc_q  <= ok_seed_i;
    end else if (take_i) begin
      err_acc_q <= err_acc_q | rsp_err_i;
      ok_acc_q  <= ok_acc_q & rsp_ok_i;
    end
  end

  // values including the response of the current cycle
  assign fin_err_o = err_acc_q | (take_i & rsp_err_i);
  assign fin_ok_o  = ok_acc_q & (!take_i | rsp_ok_i);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && rsp_err_i && !accept_i) |=> err_acc_q); // R4

endmodule

// File: rtl/xfer_merge_data.sv
module xfer_merge_data #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 first_i,
  input  logic                 split_i,
  input  logic [$clog2(DATA_W/8)-1:0] off_i,
  input  logic [1:0]           size_i,
  input  logic [DATA_W-1:0]    rsp_rdata_i,
  output logic [DATA_W-1:0]    merged_o
);

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned OFF_W = $clog2(LANES);

  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] lo_word;
  logic [DATA_W-1:0] hi_word;
  logic [DATA_W-1:0] shifted;

  // pair the two words and slide the wanted bytes down to lane zero
  function automatic logic [DATA_W-1:0] slide_pair(input logic [DATA_W-1:0] lo,
                                                   input logic [DATA_W-1:0] hi,
                                                   input logic [OFF_W-1:0]  off);
    logic [2*DATA_W-1:0] pair;
    pair = {hi, lo};
    return DATA_W'(pair >> {off, 3'b000});
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lo_q <= '0;
    else if (first_i) lo_q <= rsp_rdata_i;
  end

  assign lo_word = first_i ? rsp_rdata_i : lo_q;
  assign hi_word = split_i ? rsp_rdata_i : '0;
  assign shifted = slide_pair(lo_word, hi_word, off_i);

  for (genvar b = 0; b < LANES; b++) begin : gen_lane
    localparam logic [OFF_W:0] LANE = (OFF_W+1)'(b);
    logic keep;
    assign keep = ((LANE >> size_i) == '0);
    assign merged_o[b*8 +: 8] = shifted[b*8 +: 8] & {8{keep}};
  end

endmodule

// File: rtl/xfer_merge.sv
module xfer_merge
  import xfer_merge_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned MTYPE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic               req_store,
  input  logic               req_split,
  input  logic               req_buf0,
  input  logic               req_buf1,
  input  logic [MTYPE_W-1:0] req_mtype,
  input  logic               rsp_valid,
  input  logic [DATA_W-1:0]  rsp_rdata,
  input  logic               rsp_err,
  input  logic               rsp_exokay,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [DATA_W-1:0]  out_rdata,
  output logic               out_err,
  output logic               out_exokay,
  output logic [MTYPE_W-1:0] out_mtype
);

  localparam int unsigned OFF_W = $clog2(DATA_W / 8);

  // named events
  logic             accept_evt;
  logic             quiet_evt;
  logic             collect;
  logic             take_evt;
  logic             first_evt;
  logic             final_evt;
  logic [CNT_W-1:0] need;
  logic             ok_seed;
  logic             fin_err;
  logic             fin_ok;
  logic [DATA_W-1:0] merged;

  // held descriptor
  logic [ADDR_W-1:0]  addr_q;
  logic [1:0]         size_q;
  logic               store_q;
  logic               split_q;
  logic [MTYPE_W-1:0] mtype_q;

  assign req_ready  = !collect;
  assign accept_evt = req_valid && req_ready;
  assign need       = awaited_count(req_store, req_split, req_buf0, req_buf1);
  assign ok_seed    = ok_allowed(req_store, req_split, req_buf0, req_buf1);
  assign quiet_evt  = accept_evt && (need == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= '0;
      store_q <= 1'b0;
      split_q <= 1'b0;
      mtype_q <= '0;
    end else if (accept_evt) begin
      addr_q  <= req_addr;
      size_q  <= req_size;
      store_q <= req_store;
      split_q <= req_split;
      mtype_q <= req_mtype;
    end
  end

  xfer_merge_track u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept_evt),
    .need_i      (need),
    .rsp_valid_i (rsp_valid),
    .collect_o   (collect),
    .take_o      (take_evt),
    .first_o     (first_evt),
    .last_o      (final_evt)
  );

  xfer_merge_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept_evt),
    .ok_seed_i (ok_seed),
    .take_i    (take_evt),
    .rsp_err_i (rsp_err),
    .rsp_ok_i  (rsp_exokay),
    .fin_err_o (fin_err),
    .fin_ok_o  (fin_ok)
  );

  xfer_merge_data #(.DATA_W(DATA_W)) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .first_i     (first_evt),
    .split_i     (split_q),
    .off_i       (addr_q[OFF_W-1:0]),
    .size_i      (size_q),
    .rsp_rdata_i (rsp_rdata),
    .merged_o    (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_rdata  <= '0;
      out_err    <= 1'b0;
      out_exokay <= 1'b0;
      out_mtype  <= '0;
    end else begin
      out_valid <= quiet_evt || final_evt;
      if (quiet_evt) begin
        out_addr   <= req_addr;
        out_mtype  <= req_mtype;
        out_rdata  <= '0;
        out_err    <= 1'b0;
        out_exokay <= 1'b0;
      end else if (final_evt) begin
        out_addr   <= addr_q;
        out_mtype  <= mtype_q;
        out_rdata  <= store_q ? '0 : merged;
        out_err    <= fin_err;
        out_exokay <= fin_ok;
      end
    end
  end

  AST_REPORT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    final_evt |=> out_valid); // R2
  AST_QUIET_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_evt |=> (out_valid && !out_err && !out_exokay)); // R5
  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !collect && !quiet_evt) |=> !out_valid); // R9
  AST_OK_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exokay) |-> $past(rsp_valid && rsp_exokay)); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (collect && $past(collect)) |-> $stable(addr_q)); // R7
  AST_STORE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (final_evt && store_q) |=> (out_rdata == '0)); // R8

endmodule

// File: tb/tb_xfer_merge.sv
module tb_xfer_merge;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_store = 1'b0;
  logic        req_split = 1'b0;
  logic        req_buf0 = 1'b0;
  logic        req_buf1 = 1'b0;
  logic [1:0]  req_mtype = '0;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic        rsp_err = 1'b0;
  logic        rsp_exokay = 1'b0;
  logic        out_valid;
  logic [31:0] out_addr;
  logic [31:0] out_rdata;
  logic        out_err;
  logic        out_exokay;
  logic [1:0]  out_mtype;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic        err;
    logic        ok;
    logic [1:0]  mt;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  xfer_merge dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_store(req_store),
    .req_split(req_split), .req_buf0(req_buf0), .req_buf1(req_buf1),
    .req_mtype(req_mtype), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .rsp_exokay(rsp_exokay), .out_valid(out_valid),
    .out_addr(out_addr), .out_rdata(out_rdata), .out_err(out_err),
    .out_exokay(out_exokay), .out_mtype(out_mtype)
  );

  task automatic check(input bit good, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a summary appears
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb.size() == 0) begin
          check(0, "R9", "unexpected summary", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_addr == e.addr, {e.tag, " R7"}, "addr", out_addr, e.addr);
          check(out_mtype == e.mt, {e.tag, " R7"}, "mtype", 32'(out_mtype), 32'(e.mt));
          check(out_rdata == e.data, {e.tag, " R8"}, "rdata", out_rdata, e.data);
          check(out_err == e.err, e.tag, "err", 32'(out_err), 32'(e.err));
          check(out_exokay == e.ok, e.tag, "exokay", 32'(out_exokay), 32'(e.ok));
        end
      end
    end
  end

  // driver: computes the expected summary, then plays the request and responses
  task automatic send(input string tag, input logic [31:0] addr, input logic [1:0] size,
                      input bit st, input bit sp, input bit b0, input bit b1,
                      input logic [1:0] mt,
                      input logic [31:0] d0, input logic [31:0] d1,
                      input bit e0, input bit e1, input bit k0, input bit k1,
                      input int gap);
    exp_t e;
    bit w0, w1;
    int off, nb;
    w0  = !st || !b0;
    w1  = sp && (!st || !b1);
    off = int'(addr[1:0]);
    nb  = 1 << size;
    e.addr = addr;
    e.mt   = mt;
    e.tag  = tag;
    e.err  = (w0 && e0) || (w1 && e1);
    if (st && (b0 || (sp && b1))) e.ok = 1'b0;
    else e.ok = k0 && (sp ? k1 : 1'b1);
    e.data = '0;
    if (!st) begin
      for (int i = 0; i < 4; i++) begin
        int src;
        src = off + i;
        if (i < nb) begin
          if (src < 4) e.data[i*8 +: 8] = d0[src*8 +: 8];
          else         e.data[i*8 +: 8] = d1[(src-4)*8 +: 8];
        end
      end
    end
    sb.push_back(e);

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk) #1;
    req_valid = 1'b1; req_addr = addr; req_size = size; req_store = st;
    req_split = sp; req_buf0 = b0; req_buf1 = b1; req_mtype = mt;
    @(posedge clk) #1;
    req_valid = 1'b0;
    if (!w0 && !w1) begin
      @(negedge clk);
      check(out_valid == 1'b1, {tag, " R5"}, "summary right after accept",
            32'(out_valid), 32'd1);
      return;
    end
    for (int h = 0; h < 2; h++) begin
      bit wh;
      wh = (h == 0) ? w0 : w1;
      if (wh) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          check(req_ready == 1'b0, {tag, " R2"}, "ready while collecting",
                32'(req_ready), 32'd0);
          @(posedge clk) #1;
        end
        rsp_valid  = 1'b1;
        rsp_rdata  = (h == 0) ? d0 : d1;
        rsp_err    = (h == 0) ? e0 : e1;
        rsp_exokay = (h == 0) ? k0 : k1;
        @(posedge clk) #1;
        rsp_valid = 1'b0;
        rsp_rdata = 32'hDEAD_BEEF;
        rsp_err = 1'b1;
        rsp_exokay = 1'b1;
      end
    end
    @(negedge clk);
    check(out_valid == 1'b1, {tag, " R2"}, "summary after final response",
          32'(out_valid), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'd0);
    @(posedge clk) #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);
    check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);

    // unsplit loads
    send("R3 ld word", 32'h0000_1000, 2'd2, 0, 0, 0, 0, 2'd1,
         32'h4433_2211, 32'h0, 0, 0, 1, 0, 1);
    send("R3 ld err", 32'h0000_2004, 2'd2, 0, 0, 0, 0, 2'd2,
         32'hCAFE_F00D, 32'h0, 1, 0, 0, 0, 0);
    send("R8 ld byte off3", 32'h0000_3003, 2'd0, 0, 0, 0, 0, 2'd3,
         32'hA1B2_C3D4, 32'h0, 0, 0, 1, 0, 2);
    send("R8 ld half off2", 32'h0000_3006, 2'd1, 0, 0, 0, 0, 2'd0,
         32'h1357_9BDF, 32'h0, 0, 0, 0, 0, 0);
    // split loads
    send("R4 split err or", 32'h0000_4001, 2'd2, 0, 1, 0, 0, 2'd1,
         32'h4433_2211, 32'h8877_6655, 0, 1, 1, 1, 2);
    send("R4 split ok and", 32'h0000_4102, 2'd2, 0, 1, 0, 0, 2'd2,
         32'h0C0B_0A09, 32'h100F_0E0D, 0, 0, 1, 0, 0);
    send("R4 split ok both", 32'h0000_4203, 2'd2, 0, 1, 0, 0, 2'd0,
         32'h2423_2221, 32'h2827_2625, 0, 0, 1, 1, 1);
    send("R8 split half off3", 32'h0000_5007, 2'd1, 0, 1, 0, 0, 2'd3,
         32'hEE11_2233, 32'h4455_66FF, 1, 0, 0, 1, 3);
    send("R10 ld buf set", 32'h0000_5101, 2'd2, 0, 1, 1, 1, 2'd1,
         32'h7766_5544, 32'h3322_1100, 0, 1, 1, 1, 1);
    // stores
    send("R5 st nonbuf err", 32'h0000_6000, 2'd2, 1, 0, 0, 0, 2'd2,
         32'h1111_1111, 32'h0, 1, 0, 1, 0, 1);
    send("R6 st nonbuf ok", 32'h0000_6010, 2'd1, 1, 0, 0, 0, 2'd1,
         32'h2222_2222, 32'h0, 0, 0, 1, 0, 0);
    send("R5 st buf", 32'h0000_6102, 2'd1, 1, 0, 1, 0, 2'd3,
         32'h0, 32'h0, 1, 1, 1, 1, 0);
    send("R5 split st allbuf", 32'h0000_6203, 2'd2, 1, 1, 1, 1, 2'd0,
         32'h0, 32'h0, 1, 1, 1, 1, 0);
    send("R5 R6 split st lo buf", 32'h0000_6302, 2'd2, 1, 1, 1, 0, 2'd2,
         32'h0, 32'h3333_3333, 0, 1, 1, 1, 2);
    send("R5 R6 split st hi buf", 32'h0000_6401, 2'd2, 1, 1, 0, 1, 2'd1,
         32'h4444_4444, 32'h0, 1, 0, 1, 1, 1);
    send("R5 R6 split st nonbuf", 32'h0000_6503, 2'd1, 1, 1, 0, 0, 2'd3,
         32'h5555_5555, 32'h6666_6666, 1, 0, 1, 1, 0);

    // stray responses while idle
    @(posedge clk) #1;
    rsp_valid = 1'b1; rsp_err = 1'b1; rsp_exokay = 1'b0; rsp_rdata = 32'hBAD0_BAD0;
    repeat (2) @(posedge clk);
    #1 rsp_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R9", "no summary for stray strobe", 32'(out_valid), 32'd0);
    check(req_ready == 1'b1, "R9", "still idle after stray strobe", 32'(req_ready), 32'd1);
    send("R9 after stray", 32'h0000_7002, 2'd1, 0, 0, 0, 0, 2'd2,
         32'h9988_7766, 32'h0, 0, 0, 1, 0, 0);

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2", "summaries outstanding", 32'(sb.size()), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule